// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 39-bit virtual address into a 56-bit physical address. It does this by reading page table entries from memory, one level at a time, starting at the root table and going down. A requester presents the virtual address, the current privilege mode and the 64-bit translation control word in one cycle. The walker then issues 64-bit entry reads over a request/response memory port. It returns either a physical address or a page fault, marked by a single-cycle completion pulse.

The walk ends at the first leaf entry it finds. A leaf in the top table maps a 1 GiB page, a leaf in the middle table maps a 2 MiB page, and a leaf in the bottom table maps a 4 KiB page. The low virtual bits that the page covers are copied straight into the result.

Translation is skipped when the enable bit of the control word is clear, or when the requester runs in machine mode. In that case the address is passed through with no memory traffic.

Top module: `pt_walker`

## Requirements
- R1: When `req_ctrl[63]` is 0, or `req_priv` is 2'b11 (machine mode), the result is `req_vaddr[55:0]` with no fault. This result is reported one cycle after the request is accepted, and no memory read is issued.
- R2: With paging on, the word index of each entry read is the concatenation {table PPN, VPN of that level}. The walk reads the top level first (VPN = vaddr[38:30]), then the middle level (vaddr[29:21]), then the bottom level (vaddr[20:12]). The root PPN is `req_ctrl[43:0]`, and each lower table's PPN is entry bits 53:10 of the entry read just before.
- R3: An entry is a leaf when bit 1 (readable) or bit 3 (executable) is set. The walk issues no further read after a leaf.
- R4: The physical address is built from entry bits 53:10 shifted left by 12. It keeps vaddr[29:0] for a top-level leaf, vaddr[20:0] for a middle-level leaf and vaddr[11:0] for a bottom-level leaf.
- R5: An entry with bit 0 (valid) clear, or with bit 2 (writable) set while bit 1 is clear, ends the walk with a fault.
- R6: A non-leaf entry at the bottom level ends the walk with a fault after three reads.
- R7: A top-level leaf with entry bits 27:10 non-zero, or a middle-level leaf with entry bits 18:10 non-zero, ends the walk with a fault.
- R8: With paging on, if `req_vaddr[63:39]` is not all copies of bit 38, the walk faults one cycle after acceptance and issues no memory read.
- R9: While `mem_req_valid` is high and `mem_req_ready` is low, the request and its address stay unchanged in the next cycle.
- R10: `req_ready` is high only when the walker is idle. A request presented while it is busy has no effect, and `rsp_done` is high for exactly one cycle per accepted request.
- R11: A synchronous low `rst_n` returns the walker to idle: `req_ready` is 1, and `rsp_done` and `mem_req_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Translation request present |
| req_vaddr | input | 64 | Virtual address to translate |
| req_priv | input | 2 | Privilege mode of the requester, 2'b11 is machine mode |
| req_ctrl | input | 64 | Translation control word: bit 63 enables paging, bits 43:0 hold the root PPN |
| req_ready | output | 1 | Walker idle, request accepted this cycle if valid |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_fault | output | 1 | Page fault, meaningful with rsp_done |
| rsp_paddr | output | 56 | Physical address, meaningful with rsp_done and no fault |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 56 | 64-bit word index of the entry |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 64 | Page table entry read |

## Verification
A bypassed request or a non-canonical address produces its result in the first cycle after the accepting edge. The bench therefore samples `rsp_done` at the first falling edge after that edge and requires it to be high there.

A walk costs three cycles per level (request, wait for data, check) plus any memory stall. The bench's memory model answers one cycle after acceptance. The bench waits at falling edges for the completion pulse, with a bound, and then compares the fault flag, address, read count and each read address. It also requires the pulse to be gone one cycle later.

Stall and busy-request cases are checked the same way: stability is checked at every stalled falling edge, and `req_ready` is checked while the foreign request is held.

// File: rtl/pw_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and the walk state type for the page table walker.
// Assumes a 64-bit entry and a three-level, 9-bit-per-level table layout.
package pw_pkg;
    localparam int XLEN_D   = 64;  // control word, entry and virtual address width
    localparam int VA_W_D   = 39;  // significant virtual address bits
    localparam int PA_W_D   = 56;  // physical address width
    localparam int LEVELS_D = 3;   // table levels
    localparam int VPN_W_D  = 9;   // index bits per level
    localparam int OFF_W_D  = 12;  // page offset bits
    localparam int PPN_W_D  = 44;  // physical page number bits
    localparam int PPN_LSB_D = 10; // lowest PPN bit within an entry
    localparam int ENTRY_LG = 3;   // log2 of entry size in bytes

    localparam logic [1:0] PRIV_MACHINE = 2'b11;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_PTE,
        ST_WAIT_RESP,
        ST_CHECK,
        ST_DONE,
        ST_FAULT
    } walk_state_t;
endpackage

// File: rtl/pw_vaddr_check.sv
`timescale 1ns/1ps
// Module: pw_vaddr_check
// Decides whether a virtual address is canonical: the bits above the
// significant range must all equal the top significant bit.
// Assumes it receives only that upper slice (top significant bit included).
module pw_vaddr_check #(
    parameter int XLEN = pw_pkg::XLEN_D,
    parameter int VA_W = pw_pkg::VA_W_D,
    localparam int EXT_W = XLEN - VA_W + 1
) (
    input  logic [EXT_W-1:0] upper_bits,
    output logic             canonical
);
    // All ones or all zeros over the sign-extension slice
    always_comb begin
        canonical = (&upper_bits) | ~(|upper_bits);
    end
endmodule

// File: rtl/pw_pte_decode.sv
`timescale 1ns/1ps
// Module: pw_pte_decode
// Classifies one page table entry at a given level: bad encoding, leaf,
// misaligned superpage, and the PPN that points at the next table.
// Assumes flag bits V=0, R=1, W=2, X=3 and the PPN starting at PPN_LSB.
module pw_pte_decode #(
    parameter int XLEN    = pw_pkg::XLEN_D,
    parameter int LEVELS  = pw_pkg::LEVELS_D,
    parameter int VPN_W   = pw_pkg::VPN_W_D,
    parameter int PPN_W   = pw_pkg::PPN_W_D,
    parameter int PPN_LSB = pw_pkg::PPN_LSB_D,
    localparam int LVL_W  = $clog2(LEVELS)
) (
    input  logic [XLEN-1:0]  pte,
    input  logic [LVL_W-1:0] level,
    output logic             bad_fmt,
    output logic             leaf,
    output logic             misaligned,
    output logic             last_level,
    output logic [PPN_W-1:0] ppn
);
    localparam int FLAG_V = 0;
    localparam int FLAG_R = 1;
    localparam int FLAG_W = 2;
    localparam int FLAG_X = 3;
    localparam int TOP_USED = PPN_LSB + PPN_W;

    logic [LEVELS-1:0] mis_per_level;
    logic              unused_bits;

    // Extract the page number field
    assign ppn = pte[PPN_LSB +: PPN_W];

    // Per-level alignment test: a leaf at level L needs its low L*VPN_W PPN bits clear
    generate
        for (genvar lv = 0; lv < LEVELS; lv++) begin : g_align
            if (lv == 0) begin : g_base
                assign mis_per_level[lv] = 1'b0;
            end else begin : g_super
                assign mis_per_level[lv] = |ppn[lv*VPN_W-1:0];
            end
        end
    endgenerate

    // Flag decode and level selection
    always_comb begin
        bad_fmt    = ~pte[FLAG_V] | (pte[FLAG_W] & ~pte[FLAG_R]);
        leaf       = pte[FLAG_R] | pte[FLAG_X];
        misaligned = mis_per_level[level];
        last_level = (level == '0);
    end

    // Reserved and software bits are not inspected
    assign unused_bits = ^{pte[XLEN-1:TOP_USED], pte[PPN_LSB-1:FLAG_X+1]};
endmodule

// File: rtl/pw_paddr_form.sv
`timescale 1ns/1ps
// Module: pw_paddr_form
// Builds the physical address for a leaf found at a given level: page
// number bits above the page size, virtual bits below it.
// Assumes the page size at level L is 2**(OFF_W + L*VPN_W) bytes.
module pw_paddr_form #(
    parameter int PA_W   = pw_pkg::PA_W_D,
    parameter int LEVELS = pw_pkg::LEVELS_D,
    parameter int VPN_W  = pw_pkg::VPN_W_D,
    parameter int OFF_W  = pw_pkg::OFF_W_D,
    parameter int PPN_W  = pw_pkg::PPN_W_D,
    localparam int LVL_W  = $clog2(LEVELS),
    localparam int LOW_W  = (LEVELS-1)*VPN_W + OFF_W,
    localparam int FULL_W = PPN_W + OFF_W
) (
    input  logic [PPN_W-1:0] ppn,
    input  logic [LOW_W-1:0] va_low,
    input  logic [LVL_W-1:0] level,
    output logic [PA_W-1:0]  paddr
);
    logic [FULL_W-1:0] page_base;
    logic [FULL_W-1:0] cand [LEVELS];

    assign page_base = {ppn, {OFF_W{1'b0}}};

    // One candidate per page size
    generate
        for (genvar lv = 0; lv < LEVELS; lv++) begin : g_size
            localparam int KEEP = lv*VPN_W + OFF_W;
            assign cand[lv] = {page_base[FULL_W-1:KEEP], va_low[KEEP-1:0]};
        end
    endgenerate

    // Pick the candidate for the level where the leaf was found
    always_comb begin
        paddr = PA_W'(cand[level]);
    end
endmodule

// File: rtl/pt_walker.sv
`timescale 1ns/1ps
// Module: pt_walker
// Translates a virtual address by walking a multi-level page table in memory.
// It accepts one request in idle and reads one entry per level over a
// valid/ready memory port. It finishes with a one-cycle done pulse that
// carries either a physical address or a fault.
// Assumes memory returns exactly one response per accepted request, and that
// the memory port addresses 64-bit words.
module pt_walker #(
    parameter int XLEN    = pw_pkg::XLEN_D,
    parameter int VA_W    = pw_pkg::VA_W_D,
    parameter int PA_W    = pw_pkg::PA_W_D,
    parameter int LEVELS  = pw_pkg::LEVELS_D,
    parameter int VPN_W   = pw_pkg::VPN_W_D,
    parameter int OFF_W   = pw_pkg::OFF_W_D,
    parameter int PPN_W   = pw_pkg::PPN_W_D,
    parameter int PPN_LSB = pw_pkg::PPN_LSB_D
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [XLEN-1:0] req_vaddr,
    input  logic [1:0]      req_priv,
    input  logic [XLEN-1:0] req_ctrl,
    output logic            req_ready,
    output logic            rsp_done,
    output logic            rsp_fault,
    output logic [PA_W-1:0] rsp_paddr,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic [PA_W-1:0] mem_req_addr,
    input  logic            mem_rsp_valid,
    input  logic [XLEN-1:0] mem_rsp_data
);
    import pw_pkg::*;

    localparam int LVL_W    = $clog2(LEVELS);
    localparam int EXT_W    = XLEN - VA_W + 1;
    localparam int LOW_W    = (LEVELS-1)*VPN_W + OFF_W;
    localparam int MODE_BIT = XLEN - 1;
    localparam int BYTE_W   = PPN_W + OFF_W;

    walk_state_t      state;
    logic [LVL_W-1:0] level;
    logic [PPN_W-1:0] base_ppn;
    logic [VA_W-1:0]  va_q;
    logic [XLEN-1:0]  pte_q;
    logic [PA_W-1:0]  paddr_q;

    logic             canonical;
    logic             bypass;
    logic             accept;
    logic [VPN_W-1:0] vpn_sel;
    logic [BYTE_W-1:0] byte_addr;

    logic             pte_bad;
    logic             pte_leaf;
    logic             pte_misaligned;
    logic             pte_last;
    logic [PPN_W-1:0] pte_ppn;
    logic [PA_W-1:0]  leaf_paddr;
    logic             unused_ctrl;

    // Sign-extension test on the incoming address
    pw_vaddr_check #(
        .XLEN (XLEN),
        .VA_W (VA_W)
    ) u_vcheck (
        .upper_bits (req_vaddr[XLEN-1:VA_W-1]),
        .canonical  (canonical)
    );

    // Classification of the entry held from the last read
    pw_pte_decode #(
        .XLEN    (XLEN),
        .LEVELS  (LEVELS),
        .VPN_W   (VPN_W),
        .PPN_W   (PPN_W),
        .PPN_LSB (PPN_LSB)
    ) u_decode (
        .pte        (pte_q),
        .level      (level),
        .bad_fmt    (pte_bad),
        .leaf       (pte_leaf),
        .misaligned (pte_misaligned),
        .last_level (pte_last),
        .ppn        (pte_ppn)
    );

    // Result address for a leaf at the current level
    pw_paddr_form #(
        .PA_W   (PA_W),
        .LEVELS (LEVELS),
        .VPN_W  (VPN_W),
        .OFF_W  (OFF_W),
        .PPN_W  (PPN_W)
    ) u_form (
        .ppn    (pte_ppn),
        .va_low (va_q[LOW_W-1:0]),
        .level  (level),
        .paddr  (leaf_paddr)
    );

    // Request acceptance and bypass decision
    always_comb begin
        req_ready = (state == ST_IDLE);
        accept    = req_ready & req_valid;
        bypass    = ~req_ctrl[MODE_BIT] | (req_priv == PRIV_MACHINE);
    end

    // Entry address: table base plus index times entry size, as a word index
    always_comb begin
        vpn_sel   = va_q[OFF_W + int'(level)*VPN_W +: VPN_W];
        byte_addr = {base_ppn, {OFF_W{1'b0}}}
                  + BYTE_W'({vpn_sel, {ENTRY_LG{1'b0}}});
        mem_req_addr = PA_W'(byte_addr >> ENTRY_LG);
    end

    // Port outputs decoded from the state register
    always_comb begin
        mem_req_valid = (state == ST_READ_PTE);
        rsp_done      = (state == ST_DONE) | (state == ST_FAULT);
        rsp_fault     = (state == ST_FAULT);
        rsp_paddr     = paddr_q;
    end

    // Walk sequencer: accept, read per level, classify, finish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            level    <= '0;
            base_ppn <= '0;
            va_q     <= '0;
            pte_q    <= '0;
            paddr_q  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        va_q <= req_vaddr[VA_W-1:0];
                        if (bypass) begin
                            paddr_q <= req_vaddr[PA_W-1:0];
                            state   <= ST_DONE;
                        end else if (!canonical) begin
                            paddr_q <= '0;
                            state   <= ST_FAULT;
                        end else begin
                            base_ppn <= req_ctrl[PPN_W-1:0];
                            level    <= LVL_W'(LEVELS-1);
                            state    <= ST_READ_PTE;
                        end
                    end
                end
                ST_READ_PTE: begin
                    if (mem_req_ready) begin
                        state <= ST_WAIT_RESP;
                    end
                end
                ST_WAIT_RESP: begin
                    if (mem_rsp_valid) begin
                        pte_q <= mem_rsp_data;
                        state <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (pte_bad) begin
                        paddr_q <= '0;
                        state   <= ST_FAULT;
                    end else if (pte_leaf) begin
                        if (pte_misaligned) begin
                            paddr_q <= '0;
                            state   <= ST_FAULT;
                        end else begin
                            paddr_q <= leaf_paddr;
                            state   <= ST_DONE;
                        end
                    end else if (pte_last) begin
                        paddr_q <= '0;
                        state   <= ST_FAULT;
                    end else begin
                        base_ppn <= pte_ppn;
                        level    <= level - 1'b1;
                        state    <= ST_READ_PTE;
                    end
                end
                ST_DONE, ST_FAULT: begin
                    state <= ST_IDLE;
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    // Control word bits between the root PPN and the enable bit are ignored
    assign unused_ctrl = ^req_ctrl[MODE_BIT-1:PPN_W];
endmodule

// File: rtl/pt_walker_sva.sv
`timescale 1ns/1ps
// Module: pt_walker_sva
// Port-level protocol and timing properties of pt_walker, attached by bind.
// Assumes a synchronous active-low reset asserted from time zero.
module pt_walker_sva #(
    parameter int XLEN = 64,
    parameter int VA_W = 39,
    parameter int PA_W = 56
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [XLEN-1:0] req_vaddr,
    input logic [1:0]      req_priv,
    input logic [XLEN-1:0] req_ctrl,
    input logic            req_ready,
    input logic            rsp_done,
    input logic            rsp_fault,
    input logic [PA_W-1:0] rsp_paddr,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic [PA_W-1:0] mem_req_addr
);
    logic chk_bypass;
    logic chk_canon;

    // Independent view of bypass and sign extension from the request ports
    always_comb begin
        chk_bypass = !req_ctrl[XLEN-1] || (req_priv == 2'b11);
        chk_canon  = (req_vaddr[XLEN-1:VA_W-1] == '0) || (req_vaddr[XLEN-1:VA_W-1] == '1);
    end

    // R11: reset leaves the block idle and quiet
    p_reset_idle_r11: assert property (@(posedge clk)
        !rst_n |=> (req_ready && !rsp_done && !mem_req_valid));

    // R1: bypassed request returns its own low bits next cycle without memory traffic
    p_bypass_next_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && chk_bypass) |=>
        (rsp_done && !rsp_fault && !mem_req_valid && rsp_paddr == $past(req_vaddr[PA_W-1:0])));

    // R8: non-canonical address with paging on faults next cycle without memory traffic
    p_noncanon_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !chk_bypass && !chk_canon) |=>
        (rsp_done && rsp_fault && !mem_req_valid));

    // R9: a stalled read request keeps its address
    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R10: completion is a single-cycle pulse followed by idle
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> (!rsp_done && req_ready));

    // R10: an idle walker neither reads nor completes
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_req_valid && !rsp_done));
endmodule

bind pt_walker pt_walker_sva #(
    .XLEN (XLEN),
    .VA_W (VA_W),
    .PA_W (PA_W)
) i_pt_walker_sva (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_vaddr     (req_vaddr),
    .req_priv      (req_priv),
    .req_ctrl      (req_ctrl),
    .req_ready     (req_ready),
    .rsp_done      (rsp_done),
    .rsp_fault     (rsp_fault),
    .rsp_paddr     (rsp_paddr),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr)
);

// File: tb/test_pt_walker.sv
`timescale 1ns/1ps
// Bench for pt_walker: table-driven walks against a behavioural memory,
// followed by directed reset, stall and busy-request cases.
module test_pt_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] req_vaddr = '0;
    logic [1:0]  req_priv = '0;
    logic [63:0] req_ctrl = '0;
    logic        req_ready;
    logic        rsp_done;
    logic        rsp_fault;
    logic [55:0] rsp_paddr;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [55:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;

    int n_checks = 0;
    int n_fail = 0;

    // 200 MHz clock
    always #2.5 clk = ~clk;

    pt_walker i_pt_walker (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_vaddr     (req_vaddr),
        .req_priv      (req_priv),
        .req_ctrl      (req_ctrl),
        .req_ready     (req_ready),
        .rsp_done      (rsp_done),
        .rsp_fault     (rsp_fault),
        .rsp_paddr     (rsp_paddr),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data)
    );

    typedef struct packed {
        logic [31:0] tag;
        logic [63:0] va;
        logic [1:0]  priv;
        logic [63:0] ctrl;
        logic [63:0] p2;
        logic [63:0] p1;
        logic [63:0] p0;
        logic        flt;
        logic [55:0] pa;
        logic [1:0]  nrd;
    } vec_t;

    localparam logic [63:0] CTRL_ON = 64'h8000_0000_0000_0100;
    localparam logic [63:0] VA_STD  = 64'h0000_0000_4040_3045;
    localparam int NVEC = 13;
    localparam vec_t VECS [NVEC] = '{
        '{"R1  ", 64'hABCD_0012_3456_789A, 2'b01, 64'h0, 64'h0, 64'h0, 64'h0, 1'b0, 56'hCD_0012_3456_789A, 2'd0},
        '{"R1  ", VA_STD, 2'b11, CTRL_ON, 64'h0, 64'h0, 64'h0, 1'b0, 56'h4040_3045, 2'd0},
        '{"R4  ", VA_STD, 2'b01, CTRL_ON, 64'h80001, 64'hC0001, 64'h48D1403, 1'b0, 56'h1234_5045, 2'd3},
        '{"R4  ", VA_STD, 2'b01, CTRL_ON, 64'h80001, 64'h10000B, 64'h0, 1'b0, 56'h40_3045, 2'd2},
        '{"R4  ", VA_STD, 2'b00, CTRL_ON, 64'h1000_0009, 64'h0, 64'h0, 1'b0, 56'h4040_3045, 2'd1},
        '{"R3  ", 64'hFFFF_FFC0_4040_3045, 2'b01, CTRL_ON, 64'h80001, 64'hC0001, 64'h48D1409, 1'b0, 56'h1234_5045, 2'd3},
        '{"R5  ", VA_STD, 2'b01, CTRL_ON, 64'h80000, 64'h0, 64'h0, 1'b1, 56'h0, 2'd1},
        '{"R5  ", VA_STD, 2'b01, CTRL_ON, 64'h80001, 64'hC0005, 64'h0, 1'b1, 56'h0, 2'd2},
        '{"R6  ", VA_STD, 2'b01, CTRL_ON, 64'h80001, 64'hC0001, 64'hC0001, 1'b1, 56'h0, 2'd3},
        '{"R7  ", VA_STD, 2'b01, CTRL_ON, 64'h1000_0403, 64'h0, 64'h0, 1'b1, 56'h0, 2'd1},
        '{"R7  ", VA_STD, 2'b01, CTRL_ON, 64'h80001, 64'h100403, 64'h0, 1'b1, 56'h0, 2'd2},
        '{"R8  ", 64'h0000_0040_0000_0000, 2'b01, CTRL_ON, 64'h0, 64'h0, 64'h0, 1'b1, 56'h0, 2'd0},
        '{"R8  ", 64'hFFFF_FF00_4040_3045, 2'b00, CTRL_ON, 64'h0, 64'h0, 64'h0, 1'b1, 56'h0, 2'd0}
    };

    // Behavioural memory state
    logic [63:0] pte_tab [3];
    logic [55:0] rd_addr [3];
    int          nreads = 0;
    int          hold_err = 0;
    int          stall_cfg = 0;
    int          stall_cnt = 0;
    bit          pending = 1'b0;
    bit          seen = 1'b0;
    logic [55:0] held_addr = '0;

    // Memory model: optional stall, accept, answer one cycle later
    always @(negedge clk) begin
        mem_rsp_valid = 1'b0;
        mem_req_ready = 1'b0;
        if (!rst_n) begin
            pending   = 1'b0;
            seen      = 1'b0;
            stall_cnt = stall_cfg;
        end else if (pending) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = (nreads >= 1 && nreads <= 3) ? pte_tab[nreads-1] : 64'h0;
            pending       = 1'b0;
        end else if (mem_req_valid) begin
            if (!seen) begin
                seen      = 1'b1;
                held_addr = mem_req_addr;
            end else if (mem_req_addr !== held_addr) begin
                hold_err++;
            end
            if (stall_cnt > 0) begin
                stall_cnt--;
            end else begin
                mem_req_ready = 1'b1;
                if (nreads < 3) rd_addr[nreads] = mem_req_addr;
                nreads++;
                pending   = 1'b1;
                seen      = 1'b0;
                stall_cnt = stall_cfg;
            end
        end
    end

    // Record one check and report it if it failed
    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected word index of the i-th read from the requirement R2
    function automatic logic [55:0] exp_addr(input vec_t v, input int i);
        case (i)
            0:       return 56'({v.ctrl[43:0], v.va[38:30]});
            1:       return 56'({v.p2[53:10], v.va[29:21]});
            default: return 56'({v.p1[53:10], v.va[20:12]});
        endcase
    endfunction

    // Issue one vector, optionally poke a foreign request while busy, then check
    task automatic run_vec(input vec_t v, input bit poke_busy);
        string t;
        int cyc;
        t = $sformatf("%s", v.tag);
        pte_tab[0] = v.p2;
        pte_tab[1] = v.p1;
        pte_tab[2] = v.p0;
        nreads   = 0;
        hold_err = 0;
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = v.va;
        req_priv  = v.priv;
        req_ctrl  = v.ctrl;
        @(negedge clk);
        req_valid = 1'b0;
        if (v.nrd == 0) begin
            // R1 / R8: result due in the first cycle after acceptance
            chk(rsp_done === 1'b1, {t, " result one cycle after accept"}, 64'(rsp_done), 64'd1);
        end
        if (poke_busy) begin
            // R10: requests while busy are refused and have no effect
            for (int k = 0; k < 2; k++) begin
                req_valid = 1'b1;
                req_vaddr = 64'h0000_00AA_5555_0000;
                req_priv  = 2'b11;
                req_ctrl  = 64'h0;
                chk(req_ready === 1'b0, "R10 ready low while busy", 64'(req_ready), 64'd0);
                @(negedge clk);
            end
            req_valid = 1'b0;
        end
        cyc = 0;
        while (rsp_done !== 1'b1 && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
        chk(rsp_done === 1'b1, {t, " completion seen"}, 64'(rsp_done), 64'd1);
        chk(rsp_fault === v.flt, {t, " fault flag"}, 64'(rsp_fault), 64'(v.flt));
        if (!v.flt) begin
            chk(rsp_paddr === v.pa, {t, " physical address"}, 64'(rsp_paddr), 64'(v.pa));
        end
        chk(nreads == int'(v.nrd), {t, " R3 entry read count"}, 64'(nreads), 64'(v.nrd));
        for (int i = 0; i < 3; i++) begin
            if (i < int'(v.nrd) && i < nreads) begin
                chk(rd_addr[i] === exp_addr(v, i), "R2 entry word index", 64'(rd_addr[i]), 64'(exp_addr(v, i)));
            end
        end
        chk(hold_err == 0, "R9 request stable while stalled", 64'(hold_err), 64'd0);
        @(negedge clk);
        chk(rsp_done === 1'b0, "R10 done lasts one cycle", 64'(rsp_done), 64'd0);
    endtask

    // Watchdog: a hung run is a failed check
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R10 watchdog actual=%0d expected=%0d", 100000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Main sequence
    initial begin
        repeat (3) @(negedge clk);
        // R11: state held in reset
        chk(req_ready === 1'b1, "R11 ready in reset", 64'(req_ready), 64'd1);
        chk(rsp_done === 1'b0, "R11 done low in reset", 64'(rsp_done), 64'd0);
        chk(mem_req_valid === 1'b0, "R11 no read in reset", 64'(mem_req_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table
        for (int n = 0; n < NVEC; n++) begin
            run_vec(VECS[n], 1'b0);
        end

        // R9: stalled memory port, three stall cycles per read
        stall_cfg = 3;
        stall_cnt = 3;
        run_vec(VECS[2], 1'b0);
        stall_cfg = 0;
        stall_cnt = 0;

        // R10: foreign request while busy is ignored
        run_vec(VECS[3], 1'b1);
        repeat (4) begin
            @(negedge clk);
            chk(rsp_done === 1'b0, "R10 no extra completion", 64'(rsp_done), 64'd0);
        end

        // R11: reset in the middle of a walk
        pte_tab[0] = VECS[2].p2;
        pte_tab[1] = VECS[2].p1;
        pte_tab[2] = VECS[2].p0;
        nreads = 0;
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = VECS[2].va;
        req_priv  = VECS[2].priv;
        req_ctrl  = VECS[2].ctrl;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(req_ready === 1'b1, "R11 idle after mid-walk reset", 64'(req_ready), 64'd1);
        chk(mem_req_valid === 1'b0, "R11 read dropped by reset", 64'(mem_req_valid), 64'd0);
        rst_n = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk(rsp_done === 1'b0, "R11 no completion after reset", 64'(rsp_done), 64'd0);
        end

        // Walker usable again after reset
        run_vec(VECS[4], 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule